// File: doc/BRIEF.md
# I2C Clock Stretch Timeout Detector

This block sits next to an I2C host controller and watches for a target that keeps SCL pulled low for too long once an acknowledge bit has gone by. The host engine gives it a one-cycle pulse at the end of every ninth (ACK) bit. It also reports whether the host is currently releasing SCL, and passes on the synchronised SCL line level. A window opens at each ACK pulse. While the window is open and detection is enabled, every cycle in which the host releases SCL but the line still reads low is counted. When the count reaches the programmed timeout, the block emits a one-cycle event and sets a sticky interrupt state bit.

The window closes the first time SCL reads high while the host is releasing it. Each ACK can therefore produce at most one event. A write of N data bytes, where the target stretches after every ACK, gives N+1 events. A read gives one event, for the address ACK only, because the host drives the data ACKs and no pulse arrives for them. Software clears the state bit with a write-one-to-clear strobe. While a stall that has already timed out is still in progress, the state bit is held set. Software must therefore wait until SCL is released before it clears the bit. The interrupt line is the state bit gated by an enable.

Top module: `scl_stall_watch`

## Requirements
- R1: After reset, `intr_state_o`, `intr_o` and `stall_evt_o` are 0 and no ACK window is open.
- R2: A cycle is a stall cycle when all of the following hold: the window is open, `tmo_en_i`=1, `host_scl_rel_i`=1, `scl_i`=0 and `tmo_val_i`=T with T>0. The window opens on the clock edge that samples `ack_done_i`=1. `stall_evt_o` is 1, combinationally, in the T-th consecutive stall cycle, and `intr_state_o` is 1 after the following clock edge.
- R3: While `tmo_en_i`=0, no stall cycle occurs and `stall_evt_o` stays 0.
- R4: Without an `ack_done_i` pulse since the last close of the window (or since reset), a low SCL with the host releasing produces no event.
- R5: A stall that ends (SCL read high with host releasing) before its T-th cycle produces no event, and that SCL-high cycle closes the window. A later low SCL produces no event until the next ACK pulse.
- R6: With `intr_clr_i`=1 and no stall cycle at or past the timeout, `intr_state_o` is 0 after the edge. If a set and a clear happen in the same cycle, the set wins.
- R7: A clear issued while a timed-out stall is still in progress leaves `intr_state_o` at 1.
- R8: `intr_o` equals `intr_state_o` when `intr_en_i`=1 and is 0 when `intr_en_i`=0.
- R9: `tmo_val_i`=0 disables detection, and no event is produced.
- R10: One stall gives at most one `stall_evt_o` pulse, however long it lasts, and the counter saturates at T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_scl_rel_i | input | 1 | 1 when the host is not pulling SCL low |
| scl_i | input | 1 | Synchronised SCL line level |
| ack_done_i | input | 1 | One-cycle pulse at the end of a ninth (ACK) bit |
| tmo_en_i | input | 1 | Detection enable |
| tmo_val_i | input | CNT_W | Timeout in clock cycles (0 disables) |
| intr_en_i | input | 1 | Interrupt enable mask |
| intr_clr_i | input | 1 | Write-one-to-clear strobe for the state bit |
| stall_evt_o | output | 1 | One-cycle timeout event |
| intr_state_o | output | 1 | Sticky interrupt state |
| intr_o | output | 1 | Masked interrupt line |

## Verification
The bench builds the block with CNT_W = 8 and drives timeout values 0, 1, 2, 3, 4, 5 and 7. These values reach the disabled setting, the minimum timeout, stalls exactly as long as the timeout, stalls one cycle short of it, and stalls far longer than it, where saturation applies. It also runs a write-like sequence with several ACK windows, each of which must give its own event. It exercises clears that come before the stall ends, clears in the same cycle as the event, and clears that come after SCL is released.

// File: rtl/scl_stall_watch.sv
module scl_stall_watch #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_scl_rel_i,
  input  logic             scl_i,
  input  logic             ack_done_i,
  input  logic             tmo_en_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  input  logic             intr_en_i,
  input  logic             intr_clr_i,
  output logic             stall_evt_o,
  output logic             intr_state_o,
  output logic             intr_o
);

  logic             window_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stalling;
  logic             at_limit;
  logic             hold_set;

  assign stalling    = window_q & tmo_en_i & host_scl_rel_i & ~scl_i & (tmo_val_i != '0);
  assign at_limit    = cnt_q >= tmo_val_i;
  assign stall_evt_o = stalling & (cnt_q == tmo_val_i - CNT_W'(1));
  assign hold_set    = stalling & at_limit;
  assign intr_o      = intr_state_o & intr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      window_q <= 1'b0;
    else if (ack_done_i)              window_q <= 1'b1;
    else if (host_scl_rel_i && scl_i) window_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!stalling) cnt_q <= '0;
    else if (!at_limit) cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       intr_state_o <= 1'b0;
    else if (stall_evt_o || hold_set)  intr_state_o <= 1'b1;
    else if (intr_clr_i)               intr_state_o <= 1'b0;
  end

endmodule

// File: rtl/scl_stall_watch_sva.sv
module scl_stall_watch_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic host_scl_rel_i,
  input logic scl_i,
  input logic tmo_en_i,
  input logic intr_en_i,
  input logic intr_clr_i,
  input logic stall_evt_o,
  input logic intr_state_o,
  input logic intr_o
);

  p_evt_sets_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_evt_o |=> intr_state_o);

  p_no_evt_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_evt_o |-> tmo_en_i);

  p_evt_needs_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_evt_o |-> (host_scl_rel_i && !scl_i));

  p_clear_when_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_clr_i && scl_i) |=> !intr_state_o);

  p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intr_en_i |-> !intr_o);

  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_evt_o |=> !stall_evt_o);

endmodule

bind scl_stall_watch scl_stall_watch_sva u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_scl_rel_i(host_scl_rel_i),
  .scl_i         (scl_i),
  .tmo_en_i      (tmo_en_i),
  .intr_en_i     (intr_en_i),
  .intr_clr_i    (intr_clr_i),
  .stall_evt_o   (stall_evt_o),
  .intr_state_o  (intr_state_o),
  .intr_o        (intr_o)
);

// File: tb/scl_stall_watch_tb.sv
module scl_stall_watch_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rel = 1'b0, scl = 1'b0, ack = 1'b0, en = 1'b1;
  logic [CNT_W-1:0] tval = '0;
  logic ien = 1'b1, clr = 1'b0;
  logic evt, state, irq;

  int checks = 0, errors = 0, win = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  scl_stall_watch #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_scl_rel_i(host_rel), .scl_i(scl),
    .ack_done_i(ack), .tmo_en_i(en), .tmo_val_i(tval), .intr_en_i(ien),
    .intr_clr_i(clr), .stall_evt_o(evt), .intr_state_o(state), .intr_o(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      win++;
      if (evt) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3/R4/R5/R9/R10: event at window %0d, expected none (-1)", win);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != win) begin
            errors++;
            $display("FAIL R2: event at window %0d expected %0d", win, e);
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic stall(input int t, input int len, input bit do_ack, input bit expect_evt);
    tval = CNT_W'(t);
    if (do_ack) begin
      ack = 1'b1; host_rel = 1'b0; scl = 1'b0;
      step();
      ack = 1'b0;
    end
    host_rel = 1'b1; scl = 1'b0;
    for (int i = 1; i <= len; i++) begin
      if (expect_evt && i == t) exp_q.push_back(win + 1);
      step();
    end
  endtask

  task automatic release_scl();
    host_rel = 1'b1; scl = 1'b1;
    step(); step();
    host_rel = 1'b0; scl = 1'b0;
    step();
  endtask

  task automatic clear();
    clr = 1'b1;
    step();
    clr = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk(state == 0 && irq == 0 && evt == 0, "R1 reset outputs", {state, irq, evt}, 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(state == 0, "R1 state after reset", state, 0);

    stall(2, 10, 1'b0, 1'b0);
    release_scl();
    chk(state == 0, "R4 no window, no state", state, 0);

    stall(1, 4, 1'b1, 1'b1);
    release_scl();
    chk(state == 1, "R2 T=1 sets state", state, 1);
    ien = 1'b0; #1;
    chk(irq == 0, "R8 masked", irq, 0);
    ien = 1'b1; #1;
    chk(irq == 1, "R8 unmasked", irq, 1);
    clear();
    chk(state == 0, "R6 clear after release", state, 0);

    stall(4, 4, 1'b1, 1'b1);
    release_scl();
    chk(state == 1, "R2 stall equal to T", state, 1);
    clear();

    stall(5, 4, 1'b1, 1'b0);
    release_scl();
    chk(state == 0, "R5 stall one short", state, 0);
    stall(5, 12, 1'b0, 1'b0);
    release_scl();
    chk(state == 0, "R5 window closed after high", state, 0);

    en = 1'b0;
    stall(2, 10, 1'b1, 1'b0);
    release_scl();
    chk(state == 0, "R3 disabled", state, 0);
    en = 1'b1;

    stall(0, 10, 1'b1, 1'b0);
    release_scl();
    chk(state == 0, "R9 zero timeout", state, 0);

    stall(7, 40, 1'b1, 1'b1);
    release_scl();
    chk(state == 1, "R10 long stall", state, 1);
    clear();

    tval = CNT_W'(3);
    ack = 1'b1; step(); ack = 1'b0;
    host_rel = 1'b1; scl = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      if (i == 3) exp_q.push_back(win + 1);
      clr = (i == 6);
      step();
      if (i == 6) chk(state == 1, "R7 early clear holds", state, 1);
    end
    clr = 1'b0;
    release_scl();
    clear();
    chk(state == 0, "R7 clear after release", state, 0);

    tval = CNT_W'(2);
    ack = 1'b1; step(); ack = 1'b0;
    host_rel = 1'b1; scl = 1'b0;
    for (int i = 1; i <= 2; i++) begin
      if (i == 2) begin exp_q.push_back(win + 1); clr = 1'b1; end
      step();
    end
    clr = 1'b0;
    chk(state == 1, "R6 set wins over clear", state, 1);
    release_scl();
    clear();

    for (int b = 0; b < 4; b++) begin
      stall(1, 3, 1'b1, 1'b1);
      release_scl();
      chk(state == 1, "R2 write-like ACK event", state, 1);
      clear();
    end

    step(); step();
    chk(exp_q.size() == 0, "R2 missing events", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule